// File: doc/BRIEF.md
# Wake-Up Exit Delay Sequencer

This block decides when a processor core may start executing again after it leaves a low-power state. A wake event is sampled together with the state being left and the type of clock source selected. The sequencer then runs the delays that this pairing calls for and raises a run enable when they have all expired. Two ready flags report whether the primary oscillator or the internal oscillator is usable.

Every exit runs a short core-preparation delay. A crystal-class source also needs an oscillator start-up delay, unless its oscillator kept running through the idle state. A crystal with a frequency multiplier needs a multiplier lock delay after the start-up delay. The preparation delay always overlaps these slower delays and is never added to them. The internal oscillator is a special case when it is woken from sleep or from the secondary-oscillator idle state. Execution starts once the preparation delay ends, and the internal-ready flag rises later, when the stabilization period is over. All delays are counted in pulses of a reference tick input. Their lengths are parameters of at least one tick each.

Top module: `wake_exit_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cpu_run`, `osc_ready`, `int_ready` and `busy` are all 0 after that edge.
- R2: A `wake` sampled high while `busy` is 0 is accepted. After that edge, `busy` is 1 and `cpu_run`, `osc_ready` and `int_ready` are 0. `cpu_run` stays 0 for as long as `busy` is 1.
- R3: Every accepted wake applies the preparation delay of `T_PREP` ticks. If it is the longest required delay (D = `T_PREP`), `cpu_run` goes high after edge D+1, counting the accepting edge as edge 0, with `tick` held high. `busy` falls at that same edge.
- R4: The preparation delay runs in parallel with the oscillator start-up delay. For a crystal source (`clk_src` = 2'b00) leaving sleep (`exit_mode` = 2'b00) or secondary idle (2'b10), D = max(`T_PREP`, `T_OST`).
- R5: For the crystal-with-multiplier source (`clk_src` = 2'b01), the lock delay `T_LOCK` starts one cycle after start-up ends. This gives D = max(`T_PREP`, `T_OST` + `T_LOCK` + 1).
- R6: Leaving the idle state in which the primary clock keeps running (`exit_mode` = 2'b01) applies no start-up or lock delay for any source, so D = `T_PREP`.
- R7: External-clock or RC sources (`clk_src` = 2'b10) never apply an oscillator start-up delay, so D = `T_PREP`.
- R8: For the internal oscillator (`clk_src` = 2'b11) leaving sleep (2'b00) or secondary idle (2'b10), `cpu_run` follows R3 with D = `T_PREP`. `int_ready` goes high after edge `T_STAB`+1 and is 0 before it.
- R9: When `cpu_run` rises, `osc_ready` rises with it for sources 2'b00, 2'b01 and 2'b10, and `int_ready` stays 0. For source 2'b11 with `exit_mode` 2'b01 or 2'b11, `int_ready` rises with `cpu_run` and `osc_ready` stays 0.
- R10: A `wake` sampled while `busy` is 1 has no effect. The run enable still rises at the time the first wake set.
- R11: The delay counters advance only on edges where `tick` is 1. Each edge of a stall with `tick` low postpones `cpu_run` by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Reference tick enable for all delay counters |
| wake | input | 1 | Wake event, sampled at the clock edge |
| exit_mode | input | 2 | State being left: 00 sleep, 01 idle on primary, 10 idle on secondary, 11 idle on internal |
| clk_src | input | 2 | Clock source: 00 crystal, 01 crystal with multiplier, 10 external/RC, 11 internal |
| cpu_run | output | 1 | Execution enable |
| osc_ready | output | 1 | Primary oscillator ready flag |
| int_ready | output | 1 | Internal oscillator stable flag |
| busy | output | 1 | Exit sequence in progress |

## Verification
The main function is tried across mode and source pairings, each measured as cycles from wake to run enable. A crystal leaving sleep tells whether the preparation and start-up delays overlap. A crystal leaving primary idle tells whether start-up is skipped correctly. The multiplier source tells whether the lock delay is chained after start-up. The internal oscillator from sleep tells the run enable apart from its own later ready flag. A tick stall and a second wake during a sequence show whether the counters and the sequence react only to the inputs that should move them.

// File: rtl/wake_seq_pkg.sv
// Package: shared encodings and the delay-plan decoder for the wake-exit sequencer.
// Assumes: exit_mode and clk_src are 2-bit codes as listed in the brief.
package wake_seq_pkg;

    typedef enum logic [1:0] {
        EXIT_SLEEP    = 2'b00,
        EXIT_IDLE_PRI = 2'b01,
        EXIT_IDLE_SEC = 2'b10,
        EXIT_IDLE_INT = 2'b11
    } exit_mode_e;

    typedef enum logic [1:0] {
        SRC_XTAL     = 2'b00,
        SRC_XTAL_MUL = 2'b01,
        SRC_EXT_RC   = 2'b10,
        SRC_INTERNAL = 2'b11
    } clk_src_e;

    // Which delays one exit needs, and which ready flag it reports.
    typedef struct packed {
        logic need_ost;   // oscillator start-up count
        logic need_lock;  // multiplier lock count after start-up
        logic need_stab;  // internal oscillator stabilization count
        logic int_sel;    // report through the internal-ready flag
    } delay_plan_t;

    function automatic delay_plan_t plan_for(exit_mode_e mode, clk_src_e src);
        delay_plan_t p;
        logic keeps_running;
        keeps_running = (mode == EXIT_IDLE_PRI);
        p.int_sel   = (src == SRC_INTERNAL);
        p.need_ost  = !keeps_running && (src == SRC_XTAL || src == SRC_XTAL_MUL);
        p.need_lock = !keeps_running && (src == SRC_XTAL_MUL);
        p.need_stab = p.int_sel && (mode == EXIT_SLEEP || mode == EXIT_IDLE_SEC);
        return p;
    endfunction

endpackage

// File: rtl/wake_tick_timer.sv
// Module: one-shot down-counter of reference ticks.
// A start pulse loads LEN and clears done. Every tick then counts down by one,
// and done is set on the tick that ends the count. done holds until the next start.
// Assumes: LEN >= 1. start takes priority over counting.
module wake_tick_timer #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    output logic done
);
    localparam int unsigned CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;
    logic          active;

    // Load on start, count ticks while active, flag the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
            done   <= 1'b0;
        end else if (start) begin
            cnt    <= CW'(LEN);
            active <= 1'b1;
            done   <= 1'b0;
        end else if (active && tick) begin
            if (cnt == CW'(1)) begin
                cnt    <= '0;
                active <= 1'b0;
                done   <= 1'b1;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end
endmodule

// File: rtl/wake_exit_ctrl.sv
// Module: sequencing control for one wake-up exit.
// It accepts a wake only when idle and latches the delay plan. It starts the
// timers, chains the lock count after start-up, and raises the run enable and
// ready flags when the required delays are done.
// Assumes: timer done outputs are cleared on the edge their start is applied.
module wake_exit_ctrl
    import wake_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake,
    input  exit_mode_e mode,
    input  clk_src_e   src,
    input  logic       prep_done,
    input  logic       ost_done,
    input  logic       lock_done,
    input  logic       stab_done,
    output logic       start_prep,
    output logic       start_ost,
    output logic       start_lock,
    output logic       start_stab,
    output logic       cpu_run,
    output logic       osc_ready,
    output logic       int_ready,
    output logic       busy
);
    delay_plan_t plan_now;
    delay_plan_t plan_q;
    logic        lock_started;
    logic        accept;
    logic        osc_ok;
    logic        finish;

    // Decode the plan for the incoming wake.
    always_comb plan_now = plan_for(mode, src);

    // Timer starts, the lock hand-off and the completion condition.
    always_comb begin
        accept     = wake && !busy;
        start_prep = accept;
        start_ost  = accept && plan_now.need_ost;
        start_stab = accept && plan_now.need_stab;
        start_lock = busy && plan_q.need_lock && ost_done && !lock_started;
        osc_ok     = !plan_q.need_ost ||
                     (ost_done && (!plan_q.need_lock || (lock_started && lock_done)));
        finish     = busy && prep_done && osc_ok;
    end

    // Sequence state, run enable and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            plan_q       <= '0;
            lock_started <= 1'b0;
            cpu_run      <= 1'b0;
            osc_ready    <= 1'b0;
            int_ready    <= 1'b0;
        end else if (accept) begin
            busy         <= 1'b1;
            plan_q       <= plan_now;
            lock_started <= 1'b0;
            cpu_run      <= 1'b0;
            osc_ready    <= 1'b0;
            int_ready    <= 1'b0;
        end else begin
            if (start_lock) begin
                lock_started <= 1'b1;
            end
            if (finish) begin
                busy      <= 1'b0;
                cpu_run   <= 1'b1;
                osc_ready <= !plan_q.int_sel;
                if (plan_q.int_sel && !plan_q.need_stab) begin
                    int_ready <= 1'b1;
                end
            end
            if (plan_q.need_stab && stab_done) begin
                int_ready <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wake_exit_seq.sv
// Module: top of the wake-up exit delay sequencer.
// It links the control block to four tick timers: preparation, oscillator
// start-up, multiplier lock and internal stabilization.
// Assumes: every delay parameter is at least 1 tick.
module wake_exit_seq #(
    parameter int unsigned T_PREP = 4,
    parameter int unsigned T_OST  = 20,
    parameter int unsigned T_LOCK = 8,
    parameter int unsigned T_STAB = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wake,
    input  logic [1:0] exit_mode,
    input  logic [1:0] clk_src,
    output logic       cpu_run,
    output logic       osc_ready,
    output logic       int_ready,
    output logic       busy
);
    import wake_seq_pkg::*;

    localparam int unsigned N_TIMERS = 4;
    localparam int unsigned LENS [N_TIMERS] = '{T_PREP, T_OST, T_LOCK, T_STAB};

    logic [N_TIMERS-1:0] starts;
    logic [N_TIMERS-1:0] dones;
    logic prep_done, ost_done, lock_done, stab_done;
    logic start_prep, start_ost, start_lock, start_stab;

    // Index map: 0 prep, 1 start-up, 2 lock, 3 stabilization.
    always_comb begin
        starts    = {start_stab, start_lock, start_ost, start_prep};
        prep_done = dones[0];
        ost_done  = dones[1];
        lock_done = dones[2];
        stab_done = dones[3];
    end

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_timer
        wake_tick_timer #(.LEN(LENS[i])) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .start (starts[i]),
            .done  (dones[i])
        );
    end

    wake_exit_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake       (wake),
        .mode       (exit_mode_e'(exit_mode)),
        .src        (clk_src_e'(clk_src)),
        .prep_done  (prep_done),
        .ost_done   (ost_done),
        .lock_done  (lock_done),
        .stab_done  (stab_done),
        .start_prep (start_prep),
        .start_ost  (start_ost),
        .start_lock (start_lock),
        .start_stab (start_stab),
        .cpu_run    (cpu_run),
        .osc_ready  (osc_ready),
        .int_ready  (int_ready),
        .busy       (busy)
    );
endmodule

// File: rtl/wake_exit_seq_chk.sv
// Checker: temporal properties of the wake-exit sequencer, bound to the top.
module wake_exit_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic wake,
    input logic cpu_run,
    input logic osc_ready,
    input logic int_ready,
    input logic busy,
    input logic prep_done,
    input logic start_prep
);
    // Reset clears every output.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!cpu_run && !osc_ready && !int_ready && !busy));

    // An accepted wake starts a sequence with outputs cleared.
    assert_wake_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !busy) |=> (busy && !cpu_run && !osc_ready && !int_ready));

    // No execution while a sequence is running.
    assert_no_run_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cpu_run);

    // The run enable never rises before the preparation delay has expired.
    assert_prep_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_run) |-> prep_done);

    // The primary ready flag only rises together with the run enable.
    assert_osc_with_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_ready) |-> cpu_run);

    // A wake during a sequence never restarts the timers.
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start_prep);
endmodule

bind wake_exit_seq wake_exit_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake       (wake),
    .cpu_run    (cpu_run),
    .osc_ready  (osc_ready),
    .int_ready  (int_ready),
    .busy       (busy),
    .prep_done  (prep_done),
    .start_prep (start_prep)
);

// File: tb/wake_exit_seq_bench.sv
`timescale 1ns/1ps
module wake_exit_seq_bench;
    localparam int T_PREP = 4;
    localparam int T_OST  = 20;
    localparam int T_LOCK = 8;
    localparam int T_STAB = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       wake = 1'b0;
    logic [1:0] exit_mode = 2'b00;
    logic [1:0] clk_src = 2'b00;
    logic       cpu_run, osc_ready, int_ready, busy;

    always #2 clk = ~clk;

    wake_exit_seq #(.T_PREP(T_PREP), .T_OST(T_OST), .T_LOCK(T_LOCK), .T_STAB(T_STAB)) u_wake_exit_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wake(wake),
        .exit_mode(exit_mode), .clk_src(clk_src),
        .cpu_run(cpu_run), .osc_ready(osc_ready), .int_ready(int_ready), .busy(busy)
    );

    typedef struct {
        int    issue;
        int    lat;
        bit    osc;
        bit    intf;
        string req;
    } exp_item_t;

    exp_item_t exp_q[$];
    int  cyc = 0;
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  reported = 0;
    logic prev_run = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    endtask

    // Monitor: on each run-enable rise, pop the expected item and compare.
    always @(negedge clk) begin
        if (rst_n && cpu_run && !prev_run) begin
            if (exp_q.size() == 0) begin
                check(0, "R3", "unexpected run rise", 1, 0);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                check((cyc - it.issue) == it.lat, it.req, "run latency", cyc - it.issue, it.lat);
                check(osc_ready == it.osc, it.req, "osc_ready at run", osc_ready, it.osc);
                check(int_ready == it.intf, it.req, "int_ready at run", int_ready, it.intf);
            end
        end
        prev_run <= cpu_run;
    end

    task automatic wait_delta(int issue, int d);
        while (cyc - issue < d) @(negedge clk);
    endtask

    // Driver: issue a wake, push what the requirements predict, wait it out.
    task automatic run_case(logic [1:0] m, logic [1:0] s, int d, bit osc, bit intf,
                            string req, int stall, int rewake_at);
        exp_item_t it;
        int issue;
        @(negedge clk);
        issue     = cyc;
        it.issue  = issue;
        it.lat    = stall + d + 2;
        it.osc    = osc;
        it.intf   = intf;
        it.req    = req;
        exp_q.push_back(it);
        exit_mode = m;
        clk_src   = s;
        wake      = 1'b1;
        tick      = (stall == 0);
        @(negedge clk);
        wake = 1'b0;
        check(busy == 1'b1 && cpu_run == 1'b0 && osc_ready == 1'b0 && int_ready == 1'b0,
              "R2", "accept clears outputs", {busy, cpu_run, osc_ready, int_ready}, 4'b1000);
        if (stall > 0) begin
            repeat (stall) @(negedge clk);
            check(cpu_run == 1'b0 && busy == 1'b1, "R11", "frozen during tick stall",
                  {busy, cpu_run}, 2'b10);
            tick = 1'b1;
        end
        if (rewake_at > 0) begin
            wait_delta(issue, rewake_at);
            exit_mode = 2'b01;
            clk_src   = 2'b10;
            wake      = 1'b1;
            @(negedge clk);
            wake = 1'b0;
        end
        while (exp_q.size() != 0 && cyc - issue < 400) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cpu_run == 0 && osc_ready == 0 && int_ready == 0 && busy == 0, "R1",
              "reset outputs", {cpu_run, osc_ready, int_ready, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: crystal from sleep, prep overlaps start-up
        run_case(2'b00, 2'b00, max2(T_PREP, T_OST), 1, 0, "R4", 0, 0);
        // R5: crystal with multiplier from sleep
        run_case(2'b00, 2'b01, max2(T_PREP, T_OST + T_LOCK + 1), 1, 0, "R5", 0, 0);
        // R5: multiplier source from secondary idle
        run_case(2'b10, 2'b01, max2(T_PREP, T_OST + T_LOCK + 1), 1, 0, "R5", 0, 0);
        // R6: crystal leaving primary idle, prep only
        run_case(2'b01, 2'b00, T_PREP, 1, 0, "R6", 0, 0);
        // R6: multiplier source leaving primary idle, no lock delay
        run_case(2'b01, 2'b01, T_PREP, 1, 0, "R6", 0, 0);
        // R7: external/RC source from sleep
        run_case(2'b00, 2'b10, T_PREP, 1, 0, "R7", 0, 0);
        // R9: internal source leaving internal idle, flag with run
        run_case(2'b11, 2'b11, T_PREP, 0, 1, "R9", 0, 0);
        // R3: internal source leaving primary idle
        run_case(2'b01, 2'b11, T_PREP, 0, 1, "R3", 0, 0);
        // R10: second wake during a crystal sequence is ignored
        run_case(2'b00, 2'b00, max2(T_PREP, T_OST), 1, 0, "R10", 0, 10);
        // R11: tick stall postpones the run enable
        run_case(2'b10, 2'b10, T_PREP, 1, 0, "R11", 30, 0);

        // R8: internal from sleep, run early, stable flag later
        begin
            exp_item_t it;
            int issue;
            @(negedge clk);
            issue    = cyc;
            it.issue = issue;
            it.lat   = T_PREP + 2;
            it.osc   = 0;
            it.intf  = 0;
            it.req   = "R8";
            exp_q.push_back(it);
            exit_mode = 2'b00;
            clk_src   = 2'b11;
            wake      = 1'b1;
            @(negedge clk);
            wake = 1'b0;
            wait_delta(issue, T_STAB + 1);
            check(int_ready == 1'b0, "R8", "int_ready before stabilization", int_ready, 0);
            check(cpu_run == 1'b1, "R8", "running during stabilization", cpu_run, 1);
            @(negedge clk);
            check(int_ready == 1'b1, "R8", "int_ready after stabilization", int_ready, 1);
            check(osc_ready == 1'b0, "R9", "osc_ready stays low", osc_ready, 0);
        end

        check(exp_q.size() == 0, "R3", "pending expected runs", exp_q.size(), 0);
        repeat (4) @(negedge clk);
        report();
    end
endmodule